// File: doc/BRIEF.md
# Write-Through Data Cache with Burst Fill

This block is a small direct-mapped data cache. It sits between a processor load/store port and a 32-bit memory bus. It has 16 lines of four 32-bit words, which gives 256 bytes. Each word has its own valid bit, so a line may be only partly valid. A read miss fetches the missing word first. If memory grants a burst on that first transfer, the three remaining words of the line follow, with the word address wrapping inside the line. The processor is released as soon as the word it asked for arrives, even if the rest of the burst is still under way.

Every store is written through to memory. The cache is updated on a store only when the word is already cached, or when the run-time `allocOnWrite` input is high. A single-cycle `flushAll` input invalidates the whole cache.

Processor protocol: the processor raises `cpuReq` with a stable address, write flag and write data, and holds them until it sees `cpuReady` high for one cycle at a rising clock edge. Memory protocol: the cache holds `memReq` and `memAddr` until `memAck` is high for one cycle. On a read, `memRdata` and `memBurstOk` are valid in the cycle of that `memAck`.

Top module: `wtDataCache`

## Requirements
- R1: After reset every word is invalid, and `cpuReady` and `memReq` are low. The first read of any address is therefore a miss.
- R2: The address fields are fixed: word select is address bits [3:2], line index is bits [7:4], and tag is bits [31:8]. A read hits only when the stored tag matches and the addressed word is valid. On a hit, `cpuReady` rises in the same cycle as the request, with the cached word on `cpuRdata`, and no memory read is issued.
- R3: On a read miss, the cache holds `memReq` high with `memWe` low and `memAddr` equal to the word-aligned request address. If `memBurstOk` is low at `memAck`, only that one word becomes valid. `cpuReady` is high in the `memAck` cycle, with `memRdata` passed to `cpuRdata`.
- R4: If `memBurstOk` is high at the first `memAck` of a fill, three more reads follow. Their word indexes are the start word plus 1, plus 2 and plus 3, modulo 4, all in the same line. After the last one, all four words hit. `cpuReady` pulses only once, on the first transfer.
- R5: Every write issues `memReq` with `memWe` high and carries the processor address and data. `cpuReady` is high in the `memAck` cycle. A write that hits also updates the cached word.
- R6: If `allocOnWrite` is low, a write miss leaves the cache unchanged. A later read of that address misses and gets the new data from memory.
- R7: If `allocOnWrite` is high, a write miss makes the written word valid with the written data. A later read of that address hits.
- R8: A fill, or an allocating write, whose tag differs from the stored tag replaces the tag and clears all four valid bits of that line. Only the newly written word or words are then valid.
- R9: A `flushAll` pulse clears every valid bit at the next clock edge. It overrides a valid bit being set in the same cycle. The processor still receives the word delivered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while cpuReady is high |
| cpuReady | output | 1 | Access complete in this cycle |
| allocOnWrite | input | 1 | 1 = a write miss allocates the word |
| flushAll | input | 1 | Invalidate every word at the next edge |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memBurstReq | output | 1 | High on the first transfer of a fill, offering a burst |
| memAck | input | 1 | Transfer done; read data is valid |
| memBurstOk | input | 1 | Memory grants a four-word burst, sampled at the first fill acknowledge |
| memRdata | input | 32 | Memory read data |

## Verification
An invalidate request can land in the same cycle as a fill transfer that is writing a word and setting its valid bit. The bench makes these coincide by having its memory model raise `flushAll` in exactly the cycle it acknowledges a read. It judges the outcome in two ways: the processor must still get the fetched word in that cycle, and a second read of the same address must miss and go back to memory. A second overlap is also checked: the processor is released on the first transfer of a burst while the remaining transfers continue. The bench counts `cpuReady` pulses across the burst and checks the wrapped address order the memory model records.

// File: rtl/wtcPkg.sv
package wtcPkg;
  localparam int WTC_WORDS = 4;
  localparam int WTC_SEL_W = $clog2(WTC_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE
  } wtcState_t;

  // strobes from the control FSM to the storage datapath
  typedef struct packed {
    logic                 lineClear;  // replace tag, drop other valid bits
    logic                 wrFill;     // write memory read data
    logic                 wrStore;    // write processor store data
    logic [WTC_SEL_W-1:0] wrWord;     // word inside the line
  } wtcStrobe_t;
endpackage

// File: rtl/wtcDatapath.sv
module wtcDatapath
  import wtcPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - WTC_SEL_W - BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flushAll,
  input  logic [IDX_W-1:0]     lineIdx,
  input  logic [TAG_W-1:0]     reqTag,
  input  logic [WTC_SEL_W-1:0] reqWord,
  input  wtcStrobe_t           strb,
  input  logic [DATA_W-1:0]    fillData,
  input  logic [DATA_W-1:0]    storeData,
  output logic                 tagMatch,
  output logic                 wordValid,
  output logic [DATA_W-1:0]    rdData
);

  logic                 anyWr;
  logic [DATA_W-1:0]    wrData;
  logic [WTC_WORDS-1:0] wordBit;

  logic [LINES-1:0][TAG_W-1:0]                  tagAll;
  logic [LINES-1:0][WTC_WORDS-1:0]              validAll;
  logic [LINES-1:0][WTC_WORDS-1:0][DATA_W-1:0] dataAll;

  assign anyWr   = strb.wrFill | strb.wrStore;
  assign wrData  = strb.wrFill ? fillData : storeData;
  assign wordBit = WTC_WORDS'(1) << strb.wrWord;

  for (genvar ln = 0; ln < LINES; ln++) begin : gLine
    logic                              lineSel;
    logic [TAG_W-1:0]                  tagQ;
    logic [WTC_WORDS-1:0]              validQ;
    logic [WTC_WORDS-1:0][DATA_W-1:0] dataQ;

    assign lineSel = anyWr && (lineIdx == IDX_W'(ln));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ   <= '0;
        validQ <= '0;
      end else begin
        if (lineSel && strb.lineClear) tagQ <= reqTag;
        if (flushAll)     validQ <= '0;  // invalidate beats any set
        else if (lineSel) validQ <= (strb.lineClear ? '0 : validQ) | wordBit;
      end
    end

    always_ff @(posedge clk) begin
      if (lineSel) dataQ[strb.wrWord] <= wrData;
    end

    assign tagAll[ln]   = tagQ;
    assign validAll[ln] = validQ;
    assign dataAll[ln]  = dataQ;
  end

  assign tagMatch  = (tagAll[lineIdx] == reqTag);
  assign wordValid = validAll[lineIdx][reqWord];
  assign rdData    = dataAll[lineIdx][reqWord];

  // checks on the storage
  logic [IDX_W-1:0] prevIdx;
  always_ff @(posedge clk) prevIdx <= lineIdx;

  assert_flush_clears_R9 : assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (validAll == '0));

  assert_clear_leaves_one_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && strb.lineClear && !flushAll) |=>
      ($countones(validAll[prevIdx]) == 1 && tagAll[prevIdx] == $past(reqTag)));

endmodule

// File: rtl/wtcControl.sv
module wtcControl
  import wtcPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - WTC_SEL_W - BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuReq,
  input  logic                 cpuWe,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 allocOnWrite,
  input  logic                 tagMatch,
  input  logic                 wordValid,
  input  logic                 memAck,
  input  logic                 memBurstOk,
  output wtcStrobe_t           strb,
  output logic [IDX_W-1:0]     lineIdx,
  output logic [TAG_W-1:0]     reqTag,
  output logic [WTC_SEL_W-1:0] reqWord,
  output logic                 fillBypass,
  output logic                 cpuReady,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memBurstReq
);

  localparam logic [WTC_SEL_W-1:0] LAST_BEAT = WTC_SEL_W'(WTC_WORDS - 1);

  wtcState_t            state, stateNx;
  logic [TAG_W-1:0]     fillTag;
  logic [IDX_W-1:0]     fillIdx;
  logic [WTC_SEL_W-1:0] startWord, beat, fillWord;
  logic [WTC_SEL_W-1:0] cpuWord;
  logic [IDX_W-1:0]     cpuIdx;
  logic [TAG_W-1:0]     cpuTag;
  logic                 hitNow, lastBeat;

  assign cpuWord  = cpuAddr[BYTE_W +: WTC_SEL_W];
  assign cpuIdx   = cpuAddr[BYTE_W + WTC_SEL_W +: IDX_W];
  assign cpuTag   = cpuAddr[ADDR_W-1 -: TAG_W];
  assign fillWord = startWord + beat;   // wraps inside the line

  assign lineIdx    = (state == ST_FILL) ? fillIdx  : cpuIdx;
  assign reqTag     = (state == ST_FILL) ? fillTag  : cpuTag;
  assign reqWord    = (state == ST_FILL) ? fillWord : cpuWord;
  assign fillBypass = (state == ST_FILL);

  assign hitNow   = tagMatch & wordValid;
  assign lastBeat = ((beat == '0) && !memBurstOk) || (beat == LAST_BEAT);

  always_comb begin
    stateNx     = state;
    strb        = '0;
    cpuReady    = 1'b0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    memAddr     = cpuAddr;
    memBurstReq = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuWe)       stateNx = ST_WRITE;
          else if (hitNow) cpuReady = 1'b1;
          else             stateNx = ST_FILL;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady = 1'b1;
          stateNx  = ST_IDLE;
          if (hitNow || allocOnWrite) begin
            strb.wrStore   = 1'b1;
            strb.wrWord    = cpuWord;
            strb.lineClear = !tagMatch;
          end
        end
      end
      ST_FILL: begin
        memReq      = 1'b1;
        memBurstReq = (beat == '0);
        memAddr     = {fillTag, fillIdx, fillWord, {BYTE_W{1'b0}}};
        if (memAck) begin
          strb.wrFill    = 1'b1;
          strb.wrWord    = fillWord;
          strb.lineClear = !tagMatch;
          if (beat == '0) cpuReady = 1'b1;
          if (lastBeat)   stateNx  = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fillTag   <= '0;
      fillIdx   <= '0;
      startWord <= '0;
      beat      <= '0;
    end else begin
      state <= stateNx;
      if (state == ST_IDLE && stateNx == ST_FILL) begin
        fillTag   <= cpuTag;
        fillIdx   <= cpuIdx;
        startWord <= cpuWord;
        beat      <= '0;
      end else if (state == ST_FILL && memAck) begin
        beat <= beat + 1'b1;
      end
    end
  end

  assert_ready_has_req_R2 : assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  assert_write_through_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cpuReq && cpuWe) |=>
      (memReq && memWe && memAddr == $past(cpuAddr)));

  assert_burst_next_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && memAck && beat != '0 && beat != LAST_BEAT) |=>
      (memReq && !memWe && memAddr[BYTE_W +: WTC_SEL_W] == $past(fillWord) + 1'b1));

  assert_single_done_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && memAck && beat == '0 && !memBurstOk) |=> !memReq);

endmodule

// File: rtl/wtDataCache.sv
module wtDataCache
  import wtcPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  input  logic              allocOnWrite,
  input  logic              flushAll,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memBurstReq,
  input  logic              memAck,
  input  logic              memBurstOk,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - WTC_SEL_W - BYTE_W;

  wtcStrobe_t           strb;
  logic [IDX_W-1:0]     lineIdx;
  logic [TAG_W-1:0]     reqTag;
  logic [WTC_SEL_W-1:0] reqWord;
  logic                 tagMatch, wordValid, fillBypass;
  logic [DATA_W-1:0]    rdData;

  wtcControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) uControl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .allocOnWrite(allocOnWrite), .tagMatch(tagMatch), .wordValid(wordValid),
    .memAck(memAck), .memBurstOk(memBurstOk), .strb(strb), .lineIdx(lineIdx),
    .reqTag(reqTag), .reqWord(reqWord), .fillBypass(fillBypass),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBurstReq(memBurstReq)
  );

  wtcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) uDatapath (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .lineIdx(lineIdx),
    .reqTag(reqTag), .reqWord(reqWord), .strb(strb), .fillData(memRdata),
    .storeData(cpuWdata), .tagMatch(tagMatch), .wordValid(wordValid),
    .rdData(rdData)
  );

  assign cpuRdata = fillBypass ? memRdata : rdData;
  assign memWdata = cpuWdata;

endmodule

// File: tb/test_wtDataCache.sv
module test_wtDataCache;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuReq = 0, cpuWe = 0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0, cpuRdata;
  logic        cpuReady;
  logic        allocOnWrite = 0;
  logic        flushTest = 0, flushMem = 0, flushAll;
  logic        memReq, memWe, memBurstReq;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 0, memBurstOk = 0;
  logic [31:0] memRdata = '0;

  always #5 clk = ~clk;  // 100 MHz
  assign flushAll = flushTest | flushMem;

  wtDataCache i_wtDataCache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .allocOnWrite(allocOnWrite), .flushAll(flushAll), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBurstReq(memBurstReq), .memAck(memAck), .memBurstOk(memBurstOk),
    .memRdata(memRdata)
  );

  int checks = 0, fails = 0;
  int rdCount = 0, beatN = 0, readyPulses = 0;
  int memLatency = 1;
  bit burstGrant = 0, flushOnAck = 0;
  logic [31:0] beatLog [8];
  logic [31:0] lastWrAddr = '0, lastWrData = '0;
  logic [31:0] memStore [logic [31:0]];

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (memStore.exists(a)) return memStore[a];
    return (a * 32'h0000_9E37) ^ 32'h5EED_0000;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (cpuReady) readyPulses++;

  // memory model: acknowledges each request after memLatency idle cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      flushMem = 0;
      if (memAck) memAck = 0;
      else if (memReq) begin
        if (waitCnt < memLatency) waitCnt++;
        else begin
          waitCnt = 0;
          memAck = 1;
          memBurstOk = burstGrant;
          if (flushOnAck) flushMem = 1;
          if (memWe) begin
            memStore[memAddr] = memWdata;
            lastWrAddr = memAddr;
            lastWrData = memWdata;
          end else begin
            memRdata = memRead(memAddr);
            rdCount++;
            if (beatN < 8) beatLog[beatN] = memAddr;
            beatN++;
          end
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waitCyc, output int memReads);
    int startRd;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    startRd = rdCount;
    waitCyc = 0;
    #2;
    while (!cpuReady && waitCyc < 200) begin
      @(negedge clk);
      #2;
      waitCyc++;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuReq = 0; cpuWe = 0;
    repeat (20) @(negedge clk);
    memReads = rdCount - startRd;
  endtask

  typedef struct packed {
    logic        we;
    logic        alloc;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        expHit;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 32'h0000_0100, 32'h0,         1'b0},
    '{1'b0, 1'b0, 32'h0000_0100, 32'h0,         1'b1},
    '{1'b0, 1'b0, 32'h0000_0104, 32'h0,         1'b0},
    '{1'b1, 1'b0, 32'h0000_0104, 32'h1111_2222, 1'b1},
    '{1'b0, 1'b0, 32'h0000_0104, 32'h0,         1'b1},
    '{1'b1, 1'b0, 32'h0000_0208, 32'h3333_4444, 1'b0},
    '{1'b0, 1'b0, 32'h0000_0208, 32'h0,         1'b0},
    '{1'b1, 1'b1, 32'h0000_030C, 32'h5555_6666, 1'b0},
    '{1'b0, 1'b0, 32'h0000_030C, 32'h0,         1'b1},
    '{1'b0, 1'b0, 32'h0001_0100, 32'h0,         1'b0},
    '{1'b0, 1'b0, 32'h0000_0104, 32'h0,         1'b0},
    '{1'b0, 1'b0, 32'h0000_0100, 32'h0,         1'b0}
  };
  string vecReq [NVEC] = '{"R1", "R2", "R3", "R5", "R5", "R6",
                           "R6", "R7", "R7", "R8", "R8", "R8"};

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    int wc, mr, pulses0;
    bit hit;

    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(cpuReady == 0, "R1 cpuReady after reset", 32'(cpuReady), 0);
    check(memReq == 0, "R1 memReq after reset", 32'(memReq), 0);

    // table walk: single-word fills, write-through, allocation, replacement
    for (int i = 0; i < NVEC; i++) begin
      allocOnWrite = VEC[i].alloc;
      access(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, wc, mr);
      if (VEC[i].we) begin
        check(lastWrAddr == VEC[i].addr, {vecReq[i], " write address"}, lastWrAddr, VEC[i].addr);
        check(lastWrData == VEC[i].wdata, {vecReq[i], " write data"}, lastWrData, VEC[i].wdata);
      end else begin
        hit = (wc == 0) && (mr == 0);
        check(hit == VEC[i].expHit, {vecReq[i], " hit/miss"}, 32'(hit), 32'(VEC[i].expHit));
        check(rd == memRead(VEC[i].addr), {vecReq[i], " read data"}, rd, memRead(VEC[i].addr));
      end
    end
    allocOnWrite = 0;

    // R4: burst starting at word 2 wraps 2,3,0,1
    burstGrant = 1;
    beatN = 0;
    pulses0 = readyPulses;
    access(0, 32'h0000_0428, 0, rd, wc, mr);
    burstGrant = 0;
    check(rd == memRead(32'h428), "R4 critical word data", rd, memRead(32'h428));
    check(mr == 4, "R4 beat count", 32'(mr), 4);
    check(beatLog[0] == 32'h428, "R4 beat0 address", beatLog[0], 32'h428);
    check(beatLog[1] == 32'h42C, "R4 beat1 address", beatLog[1], 32'h42C);
    check(beatLog[2] == 32'h420, "R4 beat2 address", beatLog[2], 32'h420);
    check(beatLog[3] == 32'h424, "R4 beat3 address", beatLog[3], 32'h424);
    check(readyPulses - pulses0 == 1, "R4 single ready pulse", 32'(readyPulses - pulses0), 1);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] a;
      a = 32'h420 + 32'(w * 4);
      access(0, a, 0, rd, wc, mr);
      check(wc == 0 && mr == 0, "R4 burst word hits", 32'(mr), 0);
      check(rd == memRead(a), "R4 burst word data", rd, memRead(a));
    end

    // R3: a miss reads memory at the aligned address without a write strobe
    beatN = 0;
    access(0, 32'h0000_0630, 0, rd, wc, mr);
    check(beatLog[0] == 32'h630 && mr == 1, "R3 miss address", beatLog[0], 32'h630);
    access(0, 32'h0000_0634, 0, rd, wc, mr);
    check(mr == 1, "R3 neighbour word not filled", 32'(mr), 1);

    // R9: flush invalidates everything
    @(negedge clk); flushTest = 1;
    @(negedge clk); flushTest = 0;
    access(0, 32'h0000_0428, 0, rd, wc, mr);
    check(mr == 1 && wc > 0, "R9 miss after flush", 32'(mr), 1);

    // R9: flush in the same cycle as a fill transfer
    flushOnAck = 1;
    access(0, 32'h0000_0504, 0, rd, wc, mr);
    flushOnAck = 0;
    check(rd == memRead(32'h504), "R9 data delivered during flush", rd, memRead(32'h504));
    access(0, 32'h0000_0504, 0, rd, wc, mr);
    check(mr == 1 && wc > 0, "R9 flush overrides fill valid", 32'(mr), 1);

    // R6: write miss without allocate leaves a cached neighbour untouched
    access(0, 32'h0000_0508, 0, rd, wc, mr);
    access(1, 32'h0000_0500, 32'hABCD_0001, rd, wc, mr);
    access(0, 32'h0000_0508, 0, rd, wc, mr);
    check(mr == 0 && wc == 0, "R6 neighbour still hits", 32'(mr), 0);
    access(0, 32'h0000_0500, 0, rd, wc, mr);
    check(mr == 1 && rd == 32'hABCD_0001, "R6 miss returns memory copy", rd, 32'hABCD_0001);

    summary();
  end

endmodule